// File: doc/BRIEF.md
# Tiny Reprogrammable 8-bit Processor Core

This block is a very small 8-bit processor. It has a writable program store of 32 words of 16 bits, a 5-bit program counter, eight 8-bit working registers, an adder/subtractor that leaves a carry flag, an 8-bit input value and a latched 8-bit output port. While reset is held high, a host writes instruction words into the program store through an address, a data word and a write strobe. The 8-bit input value arrives on the same data pins, in the bits that hold the data field of a program word.

When reset drops, the core alternates between a fetch clock and an execute clock, so one instruction finishes every two clocks. It can move a register, load an immediate, read the input value, drive the output port, add, subtract, and branch when carry is set. A subtract of a larger value from a smaller one sets carry, so a subtract followed by a branch serves as an unconditional jump.

Top module: `tiny_mcu_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core clears the program counter, the carry flag, the output port and all eight registers, and it holds the sequencer in its fetch state.
- R2: After reset is released, each instruction takes exactly two clocks. The first clock fetches the word and the second executes it. `pc_out` changes only on the execute clock. Without a taken branch it increments by one and wraps from 31 to 0.
- R3: A program word holds the opcode in bits [15:11], the data/immediate field in bits [10:3] and the register field in bits [2:0]. A clock edge with `rst` and `ld_we` both high writes `ld_data` to the word at `ld_addr`.
- R4: Opcode 0 (move) copies the register selected by data bits [2:0] into the register named by the register field.
- R5: Opcode 1 (move immediate) writes the 8-bit data field into the named register.
- R6: Opcode 2 (input) writes `ld_data[10:3]`, sampled on the execute clock, into the named register.
- R7: Opcode 3 (output) loads the named register into `out_port`. The port keeps that value until the next output instruction.
- R8: Opcode 4 (add) writes the sum, modulo 256, of the named register and the register selected by data bits [2:0] back into the named register. Carry is set to the carry-out of the sum.
- R9: Opcode 5 (subtract) writes the named register minus the selected register, modulo 256, into the named register. Carry is set exactly when the subtrahend is larger than the minuend.
- R10: Opcode 6 (branch on carry) loads the PC with data bits [4:0] when carry is set, and otherwise steps to the next word. It does not change carry.
- R11: Opcodes 7 to 31 change no register, no carry and no output. Only the PC advances.
- R12: `ld_we` has no effect on the program store while `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset; also enables program loading |
| ld_we | input | 1 | Program store write strobe |
| ld_addr | input | 5 | Program store write address |
| ld_data | input | 16 | Program word to write; bits [10:3] also carry the input value |
| out_port | output | 8 | Latched output port |
| pc_out | output | 5 | Current program counter |

## Verification
A loaded program runs through two full passes. A reference model follows every clock, and the output port and PC are compared after each edge. The add produces a carry-out and the subtracts produce both no borrow and a borrow. Together they separate the carry and borrow polarity and show whether modulo-256 wrapping happens. One branch is not taken and one is taken over a block of decoy outputs, which separates a correct target load from a fall-through. The program also contains a no-operation opcode with a nonzero register field, a PC wrap from 31 to 0, and an input read between two outputs. In the second pass the write strobe stays active with a conflicting word, which exposes any path that writes the program store outside reset.

// File: rtl/tiny_mcu_pkg.sv
package tiny_mcu_pkg;

    localparam int DATA_W  = 8;
    localparam int PC_W    = 5;
    localparam int REG_AW  = 3;
    localparam int OP_W    = 5;
    localparam int WORD_W  = OP_W + DATA_W + REG_AW;
    localparam int IMEM_DEPTH = 1 << PC_W;
    localparam int REG_COUNT  = 1 << REG_AW;

    typedef enum logic [OP_W-1:0] {
        OP_MOV  = 5'd0,
        OP_MOVI = 5'd1,
        OP_IN   = 5'd2,
        OP_OUT  = 5'd3,
        OP_ADD  = 5'd4,
        OP_SUB  = 5'd5,
        OP_BC   = 5'd6
    } opcode_e;

    typedef struct packed {
        opcode_e             op;
        logic [DATA_W-1:0]   data;
        logic [REG_AW-1:0]   rd;
    } instr_t;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        logic                wr;
        logic [REG_AW-1:0]   addr;
        logic [DATA_W-1:0]   val;
    } rf_wr_t;

    function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] pc);
        return PC_W'(pc + 1'b1);
    endfunction

endpackage

// File: rtl/tiny_mcu_progmem.sv
module tiny_mcu_progmem #(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/tiny_mcu_regfile.sv
module tiny_mcu_regfile #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    localparam int COUNT = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] regs [COUNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < COUNT; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    // R4/R5/R6: a write lands in the addressed entry and is visible on the next read
    a_r4_write_visible: assert property (@(posedge clk) disable iff (rst)
        (we && raddr_a == waddr) |=> (rdata_a == $past(wdata)) || $past(raddr_a) != raddr_a);

    // R1: reset leaves every register readable as zero
    a_r1_regs_cleared: assert property (@(posedge clk)
        rst |=> (rdata_a == '0 && rdata_b == '0));

endmodule

// File: rtl/tiny_mcu_alu.sv
module tiny_mcu_alu #(
    parameter int W = 8
) (
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         cout
);

    logic [W:0] wide;

    always_comb begin
        if (sub) begin
            wide = {1'b0, a} - {1'b0, b};
        end else begin
            wide = {1'b0, a} + {1'b0, b};
        end
        res  = wide[W-1:0];
        cout = wide[W];
    end

    // R9: borrow flag matches the magnitude comparison of the operands
    always_comb begin
        if (sub) begin
            a_r9_borrow_is_less: assert (cout == (a < b));
        end
    end

endmodule

// File: rtl/tiny_mcu_core.sv
module tiny_mcu_core
    import tiny_mcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic [PC_W-1:0]   ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    output logic [DATA_W-1:0] out_port,
    output logic [PC_W-1:0]   pc_out
);

    phase_e            phase_q;
    logic [PC_W-1:0]   pc_q;
    logic [PC_W-1:0]   pc_d;
    instr_t            ir_q;
    logic              carry_q;
    logic              carry_d;
    logic [DATA_W-1:0] out_q;
    logic [WORD_W-1:0] fetch_word;
    logic [DATA_W-1:0] ext_in;
    logic [DATA_W-1:0] a_val;
    logic [DATA_W-1:0] b_val;
    logic [DATA_W-1:0] alu_res;
    logic              alu_cout;
    logic              is_exec;
    logic              mem_we;
    rf_wr_t            rf_wr;

    assign is_exec = (phase_q == PH_EXEC);
    assign ext_in  = ld_data[REG_AW +: DATA_W];
    assign mem_we  = ld_we & rst;

    tiny_mcu_progmem #(
        .ADDR_W (PC_W),
        .WORD_W (WORD_W)
    ) i_progmem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (pc_q),
        .rdata (fetch_word)
    );

    tiny_mcu_regfile #(
        .ADDR_W (REG_AW),
        .DATA_W (DATA_W)
    ) i_regfile (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_wr.wr),
        .waddr   (rf_wr.addr),
        .wdata   (rf_wr.val),
        .raddr_a (ir_q.rd),
        .rdata_a (a_val),
        .raddr_b (ir_q.data[REG_AW-1:0]),
        .rdata_b (b_val)
    );

    tiny_mcu_alu #(
        .W (DATA_W)
    ) i_alu (
        .sub  (ir_q.op == OP_SUB),
        .a    (a_val),
        .b    (b_val),
        .res  (alu_res),
        .cout (alu_cout)
    );

    always_comb begin
        rf_wr.wr   = 1'b0;
        rf_wr.addr = ir_q.rd;
        rf_wr.val  = '0;
        carry_d    = carry_q;
        pc_d       = pc_step(pc_q);
        unique case (ir_q.op)
            OP_MOV: begin
                rf_wr.wr  = is_exec;
                rf_wr.val = b_val;
            end
            OP_MOVI: begin
                rf_wr.wr  = is_exec;
                rf_wr.val = ir_q.data;
            end
            OP_IN: begin
                rf_wr.wr  = is_exec;
                rf_wr.val = ext_in;
            end
            OP_ADD, OP_SUB: begin
                rf_wr.wr  = is_exec;
                rf_wr.val = alu_res;
                carry_d   = alu_cout;
            end
            OP_BC: begin
                if (carry_q) begin
                    pc_d = ir_q.data[PC_W-1:0];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
            carry_q <= 1'b0;
            out_q   <= '0;
        end else if (phase_q == PH_FETCH) begin
            ir_q    <= instr_t'(fetch_word);
            phase_q <= PH_EXEC;
        end else begin
            pc_q    <= pc_d;
            carry_q <= carry_d;
            if (ir_q.op == OP_OUT) begin
                out_q <= a_val;
            end
            phase_q <= PH_FETCH;
        end
    end

    assign out_port = out_q;
    assign pc_out   = pc_q;

    // R1: reset clears the visible state
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pc_out == '0 && out_port == '0 && !carry_q && phase_q == PH_FETCH));

    // R2: the PC holds across a fetch clock
    a_r2_pc_holds_on_fetch: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FETCH) |=> $stable(pc_out));

    // R2: phases alternate
    a_r2_phase_alternates: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FETCH) |=> (phase_q == PH_EXEC));

    // R2/R11: non-branch instructions step the PC by one with wrap
    a_r2_pc_steps: assert property (@(posedge clk) disable iff (rst)
        (is_exec && ir_q.op != OP_BC) |=> (pc_out == PC_W'($past(pc_out) + 1'b1)));

    // R10: a taken branch lands on the data field target
    a_r10_branch_target: assert property (@(posedge clk) disable iff (rst)
        (is_exec && ir_q.op == OP_BC && carry_q) |=> (pc_out == $past(ir_q.data[PC_W-1:0])));

    // R10: a branch leaves carry alone
    a_r10_branch_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        (is_exec && ir_q.op == OP_BC) |=> $stable(carry_q));

    // R7: the output port moves only on an output instruction
    a_r7_out_holds: assert property (@(posedge clk) disable iff (rst)
        !(is_exec && ir_q.op == OP_OUT) |=> $stable(out_port));

    // R12: no program store write while running
    a_r12_no_run_write: assert property (@(posedge clk)
        !rst |-> !mem_we);

endmodule

// File: tb/test_tiny_mcu_core.sv
module test_tiny_mcu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_we = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [7:0]  out_port;
    logic [4:0]  pc_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    tiny_mcu_core i_tiny_mcu_core (
        .clk      (clk),
        .rst      (rst),
        .ld_we    (ld_we),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .out_port (out_port),
        .pc_out   (pc_out)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_mem [32];
    logic [7:0]  m_reg [8];
    int          m_phase;
    int          m_pc;
    int          m_carry;
    int          m_out;
    logic [15:0] m_ir;

    always @(posedge clk) begin
        int op, dat, rd, a, b, s;
        if (rst) begin
            if (ld_we) m_mem[ld_addr] = ld_data;
            for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
            m_phase = 0; m_pc = 0; m_carry = 0; m_out = 0; m_ir = '0;
        end else if (m_phase == 0) begin
            m_ir = m_mem[m_pc];
            m_phase = 1;
        end else begin
            op  = int'(m_ir[15:11]);
            dat = int'(m_ir[10:3]);
            rd  = int'(m_ir[2:0]);
            a   = int'(m_reg[rd]);
            b   = int'(m_reg[dat % 8]);
            m_phase = 0;
            m_pc = (m_pc + 1) % 32;
            case (op)
                0: m_reg[rd] = 8'(b);
                1: m_reg[rd] = 8'(dat);
                2: m_reg[rd] = ld_data[10:3];
                3: m_out = a;
                4: begin s = a + b; m_carry = (s > 255) ? 1 : 0; m_reg[rd] = 8'(s % 256); end
                5: begin m_carry = (a < b) ? 1 : 0; m_reg[rd] = 8'((a - b + 256) % 256); end
                6: if (m_carry != 0) m_pc = dat % 32;
                default: ;
            endcase
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!done && !rst) begin
            check("R2 pc_out vs model", int'(pc_out), m_pc);
            check("R7 out_port vs model", int'(out_port), m_out);
        end
    end

    function automatic logic [15:0] enc(input int op, input int dat, input int rd);
        return {5'(op), 8'(dat), 3'(rd)};
    endfunction

    task automatic load(input int addr, input logic [15:0] w);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = 5'(addr); ld_data = w;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic instr(input int n);
        repeat (2 * n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state held cleared during reset
        check("R1 pc in reset", int'(pc_out), 0);
        check("R1 out in reset", int'(out_port), 0);

        // R3: program loaded through the load port during reset
        load(0,  enc(1, 8'hC8, 1));   // MOVI r1
        load(1,  enc(1, 8'h64, 2));   // MOVI r2
        load(2,  enc(3, 0, 1));       // OUT r1
        load(3,  enc(4, 2, 1));       // ADD r1,r2 -> 2C carry
        load(4,  enc(3, 0, 1));       // OUT r1
        load(5,  enc(0, 1, 3));       // MOV r3<-r1
        load(6,  enc(9, 8'hFF, 3));   // no-op opcode
        load(7,  enc(3, 0, 3));       // OUT r3
        load(8,  enc(2, 0, 4));       // IN r4
        load(9,  enc(3, 0, 4));       // OUT r4
        load(10, enc(5, 1, 2));       // SUB r2,r1 -> 38 no borrow
        load(11, enc(6, 0, 0));       // BC 0 (not taken)
        load(12, enc(3, 0, 2));       // OUT r2
        load(13, enc(5, 2, 3));       // SUB r3,r2 -> F4 borrow
        load(14, enc(3, 0, 3));       // OUT r3
        load(15, enc(6, 20, 0));      // BC 20 (taken)
        for (int k = 16; k < 20; k++) load(k, (k % 2 == 0) ? enc(1, 8'h99, 5) : enc(3, 0, 5));
        load(20, enc(3, 0, 1));       // OUT r1
        for (int k = 21; k < 32; k++) load(k, enc(0, 0, 0));

        ld_data = {5'd0, 8'hA5, 3'd0};
        @(negedge clk);
        rst = 1'b0;

        // R2: pc unchanged after the fetch clock, advanced after execute
        @(posedge clk); @(negedge clk);
        check("R2 pc after fetch", int'(pc_out), 0);
        @(posedge clk); @(negedge clk);
        check("R2 pc after execute", int'(pc_out), 1);

        instr(2);   // through #3
        check("R5 R7 out after OUT r1", int'(out_port), 8'hC8);
        instr(2);   // #5
        check("R8 add wraps", int'(out_port), 8'h2C);
        instr(2);   // #7 (no-op at 6)
        check("R11 pc after no-op", int'(pc_out), 7);
        check("R11 out untouched", int'(out_port), 8'h2C);
        instr(1);   // #8
        check("R4 move", int'(out_port), 8'h2C);
        instr(2);   // #10
        check("R6 input read", int'(out_port), 8'hA5);
        instr(2);   // #12
        check("R10 branch not taken", int'(pc_out), 12);
        instr(1);   // #13
        check("R9 subtract no borrow", int'(out_port), 8'h38);
        instr(2);   // #15
        check("R9 subtract borrow", int'(out_port), 8'hF4);
        instr(1);   // #16
        check("R10 branch taken", int'(pc_out), 20);
        instr(1);   // #17
        check("R10 decoys skipped", int'(out_port), 8'h2C);
        instr(11);  // #28
        check("R2 pc wraps", int'(pc_out), 0);

        // R12: strobe active while running with a conflicting word at 20
        ld_we = 1'b1; ld_addr = 5'd20; ld_data = enc(3, 0, 0);
        instr(17);  // pass two through pc 20
        ld_we = 1'b0;
        check("R12 load ignored while running", int'(out_port), 8'h2C);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule